// File: doc/BRIEF.md
# USB Receive Handshake Controller

This block chooses the reply that a USB device returns after the data stage of an OUT or SETUP transaction. It serves endpoint 0 and a parameterised number of further endpoints. The default is two more, which gives three in all. Every endpoint owns an 8-bit register that the CPU can write and read back. The register holds a control-endpoint flag, the data toggle the endpoint expects next, a two-bit receive status and a four-bit endpoint address. The packet decoder upstream presents one token event per transaction. The event carries the kind (SETUP or OUT), the four-bit endpoint number, the data PID (DATA0 or DATA1) and a flag that says whether the CRC was good. One clock later the block answers with ACK, NAK, STALL or silence.

When a transfer is accepted, the hardware moves the endpoint's status to NAK and flips its toggle. It also raises a correct-transfer flag that names the endpoint. Further packets are then refused until firmware has handled the data and re-armed the endpoint. SETUP tokens on control endpoints always restart the toggle sequence at DATA0. A USB bus reset returns every endpoint register and the flag to their reset values.

Register layout: bit 7 is the control flag, bit 6 is the expected toggle (0 = DATA0, 1 = DATA1), bits 5:4 are the status and bits 3:0 are the address. Status codes: 00 disabled, 01 stall, 10 nak, 11 valid. Reply code on `hs_code`: 00 none, 01 ACK, 10 NAK, 11 STALL.

Top module: `usb_rx_hs_ctrl`

## Requirements
- R1: After power-on reset, endpoint 0 reads 0x80 and every other endpoint reads 0x00. `hs_code` is 00 and `ctr_flag` is 0.
- R2: Endpoint 0 always reads bit 7 as 1 and bits 3:0 as 0, whatever is written to it. Bits 6:4 take the written value. Any other endpoint stores all 8 written bits and reads them back unchanged.
- R3: A token is matched to the lowest-numbered endpoint whose address field equals the token's endpoint number. With no match, `hs_code` stays 00 and no register or flag changes.
- R4: An OUT token with a good CRC on a matched endpoint whose status is 00, 01 or 10 gives reply 00, 11 or 10 respectively. No state changes.
- R5: An OUT token with a good CRC on a valid (11) endpoint, carrying a data PID equal to bit 6, gives ACK (01). Bit 6 inverts, the status becomes 10, `ctr_flag` sets and `ctr_ep` takes the endpoint index.
- R6: An OUT token with a good CRC on a valid endpoint, carrying a data PID that differs from bit 6, gives ACK. Toggle, status and the correct-transfer flag and index stay unchanged.
- R7: A token with a bad CRC gives no reply and changes no state.
- R8: A SETUP token with a good CRC on a matched endpoint with bit 7 set and a status other than 00 gives ACK. The toggle is first cleared. With DATA0 the endpoint ends with toggle 1 and status 10, and `ctr_flag`/`ctr_ep` are set. With DATA1 the toggle ends at 0, the status is unchanged and the flag does not change.
- R9: A SETUP token on a matched endpoint whose bit 7 is 0, or whose status is 00, gives no reply and changes no state.
- R10: `ctr_flag` stays set until a `ctr_clr` pulse clears it. If a new accepted transfer arrives in the same cycle as `ctr_clr`, the flag stays set. `ctr_ep` reports the most recent accepted endpoint.
- R11: A `bus_rst` pulse returns all endpoint registers to their reset values (endpoint 0 0x80, others 0x00) and clears `ctr_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rst | input | 1 | USB bus reset pulse, synchronous |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | IDXW | Endpoint index written |
| cfg_wdata | input | 8 | Write data |
| rd_idx | input | IDXW | Endpoint index read |
| rd_data | output | 8 | Read data (combinational) |
| tok_valid | input | 1 | Token event present this cycle |
| tok_setup | input | 1 | 1 = SETUP, 0 = OUT |
| tok_ep | input | 4 | Endpoint number from the token |
| tok_pid1 | input | 1 | Data PID is DATA1 |
| tok_crc_ok | input | 1 | Data packet CRC good |
| hs_code | output | 2 | Reply code, registered |
| ctr_clr | input | 1 | Clear correct-transfer flag |
| ctr_flag | output | 1 | Correct-transfer flag |
| ctr_ep | output | IDXW | Endpoint of the last accepted transfer |

## Verification
The hardest cases to reach are the SETUP token that arrives with DATA1, and address aliasing. In the aliasing case two endpoints hold the same address, so priority decides the match, and one of them may be disabled. Random register writes draw addresses from only four values, which makes aliasing common. Random control bits and all four statuses are also drawn. SETUP tokens arrive with either PID. Directed sequences first run an OUT accept followed by a mismatched retry, and then a SETUP with DATA1 on a stalled control endpoint.

// File: rtl/usbrx_pkg.sv
package usbrx_pkg;

  typedef enum logic [1:0] {
    ST_DIS   = 2'b00,
    ST_STALL = 2'b01,
    ST_NAK   = 2'b10,
    ST_VALID = 2'b11
  } rx_stat_e;

  typedef enum logic [1:0] {
    HS_NONE  = 2'b00,
    HS_ACK   = 2'b01,
    HS_NAK   = 2'b10,
    HS_STALL = 2'b11
  } hs_e;

  typedef struct packed {
    logic     ctrl;
    logic     tog;
    rx_stat_e stat;
    logic [3:0] addr;
  } ep_reg_t;

  localparam ep_reg_t EP0_RST = '{ctrl: 1'b1, tog: 1'b0, stat: ST_DIS, addr: 4'h0};
  localparam ep_reg_t EPN_RST = '{ctrl: 1'b0, tog: 1'b0, stat: ST_DIS, addr: 4'h0};

endpackage

// File: rtl/usbrx_ep_reg.sv
module usbrx_ep_reg
  import usbrx_pkg::*;
#(
  parameter bit FIXED_EP0 = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_rst,
  input  logic       sw_we,
  input  logic [7:0] sw_data,
  input  logic       hw_we,
  input  logic       hw_tog,
  input  logic       hw_set_nak,
  output ep_reg_t    q
);

  localparam ep_reg_t RST_VAL = FIXED_EP0 ? EP0_RST : EPN_RST;

  ep_reg_t q_r;
  ep_reg_t q_d;
  logic    q_en;

  // next-state: bus reset, then hardware update, then software write
  always_comb begin
    q_d  = q_r;
    q_en = bus_rst | hw_we | sw_we;
    if (bus_rst) begin
      q_d = RST_VAL;
    end else if (hw_we) begin
      q_d.tog = hw_tog;
      if (hw_set_nak) q_d.stat = ST_NAK;
    end else if (sw_we) begin
      q_d = ep_reg_t'(sw_data);
    end
    if (FIXED_EP0) begin
      q_d.ctrl = 1'b1;
      q_d.addr = 4'h0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= RST_VAL;
    end else if (q_en) begin
      q_r <= q_d;
    end
  end

  assign q = q_r;

  AST_NAK_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_we && hw_set_nak && !bus_rst) |=> (q_r.stat == ST_NAK)) else $error("nak"); // R5

  if (FIXED_EP0) begin : g_ep0_chk
    AST_EP0_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      sw_we |=> (q_r.ctrl && q_r.addr == 4'h0)) else $error("ep0 fixed"); // R2
  end

endmodule

// File: rtl/usbrx_hs_decide.sv
module usbrx_hs_decide
  import usbrx_pkg::*;
#(
  parameter int NUM_EP = 3,
  parameter int IDXW   = 2
) (
  input  ep_reg_t [NUM_EP-1:0] regs,
  input  logic                 tok_valid,
  input  logic                 tok_setup,
  input  logic [3:0]           tok_ep,
  input  logic                 tok_pid1,
  input  logic                 tok_crc_ok,
  output hs_e                  hs,
  output logic                 upd_we,
  output logic [IDXW-1:0]      upd_idx,
  output logic                 upd_tog,
  output logic                 upd_nak,
  output logic                 ctr_set
);

  logic [NUM_EP-1:0] hit;
  logic              found;
  logic [IDXW-1:0]   sel_idx;
  ep_reg_t           sel;

  for (genvar g = 0; g < NUM_EP; g++) begin : g_hit
    assign hit[g] = (regs[g].addr == tok_ep);
  end

  // lowest index wins: scan downward so the last assignment is the lowest
  always_comb begin
    found   = 1'b0;
    sel_idx = '0;
    for (int i = NUM_EP - 1; i >= 0; i--) begin
      if (hit[i]) begin
        found   = 1'b1;
        sel_idx = IDXW'(i);
      end
    end
    sel = regs[sel_idx];
  end

  always_comb begin
    hs      = HS_NONE;
    upd_we  = 1'b0;
    upd_idx = sel_idx;
    upd_tog = 1'b0;
    upd_nak = 1'b0;
    ctr_set = 1'b0;
    if (tok_valid && tok_crc_ok && found) begin
      if (tok_setup) begin
        if (sel.ctrl && sel.stat != ST_DIS) begin
          hs     = HS_ACK;
          upd_we = 1'b1;
          // toggle restarts at DATA0; DATA0 packet is then accepted
          if (!tok_pid1) begin
            upd_tog = 1'b1;
            upd_nak = 1'b1;
            ctr_set = 1'b1;
          end
        end
      end else begin
        unique case (sel.stat)
          ST_DIS:   hs = HS_NONE;
          ST_STALL: hs = HS_STALL;
          ST_NAK:   hs = HS_NAK;
          ST_VALID: begin
            hs = HS_ACK;
            if (tok_pid1 == sel.tog) begin
              upd_we  = 1'b1;
              upd_tog = ~sel.tog;
              upd_nak = 1'b1;
              ctr_set = 1'b1;
            end
          end
          default:  hs = HS_NONE;
        endcase
      end
    end
  end

endmodule

// File: rtl/usb_rx_hs_ctrl.sv
module usb_rx_hs_ctrl
  import usbrx_pkg::*;
#(
  parameter int NUM_EP = 3,
  localparam int IDXW = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_rst,
  input  logic            cfg_we,
  input  logic [IDXW-1:0] cfg_idx,
  input  logic [7:0]      cfg_wdata,
  input  logic [IDXW-1:0] rd_idx,
  output logic [7:0]      rd_data,
  input  logic            tok_valid,
  input  logic            tok_setup,
  input  logic [3:0]      tok_ep,
  input  logic            tok_pid1,
  input  logic            tok_crc_ok,
  output logic [1:0]      hs_code,
  input  logic            ctr_clr,
  output logic            ctr_flag,
  output logic [IDXW-1:0] ctr_ep
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rs_q;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ns = rs_q[1];

  ep_reg_t [NUM_EP-1:0] regs;
  hs_e                  hs_d;
  logic                 upd_we;
  logic [IDXW-1:0]      upd_idx;
  logic                 upd_tog;
  logic                 upd_nak;
  logic                 ctr_set;

  usbrx_hs_decide #(.NUM_EP(NUM_EP), .IDXW(IDXW)) u_dec (
    .regs       (regs),
    .tok_valid  (tok_valid),
    .tok_setup  (tok_setup),
    .tok_ep     (tok_ep),
    .tok_pid1   (tok_pid1),
    .tok_crc_ok (tok_crc_ok),
    .hs         (hs_d),
    .upd_we     (upd_we),
    .upd_idx    (upd_idx),
    .upd_tog    (upd_tog),
    .upd_nak    (upd_nak),
    .ctr_set    (ctr_set)
  );

  for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
    usbrx_ep_reg #(.FIXED_EP0(g == 0)) u_reg (
      .clk        (clk),
      .rst_n      (rst_ns),
      .bus_rst    (bus_rst),
      .sw_we      (cfg_we && (cfg_idx == IDXW'(g))),
      .sw_data    (cfg_wdata),
      .hw_we      (upd_we && (upd_idx == IDXW'(g))),
      .hw_tog     (upd_tog),
      .hw_set_nak (upd_nak),
      .q          (regs[g])
    );
  end

  // reply register and correct-transfer flag
  hs_e             hs_q;
  hs_e             hs_n;
  logic            ctr_q;
  logic            ctr_n;
  logic [IDXW-1:0] ctr_ep_q;
  logic [IDXW-1:0] ctr_ep_n;
  logic            ctr_en;

  always_comb begin
    hs_n     = bus_rst ? HS_NONE : hs_d;
    ctr_n    = ctr_q;
    ctr_ep_n = ctr_ep_q;
    ctr_en   = bus_rst | ctr_set | ctr_clr;
    if (bus_rst) begin
      ctr_n    = 1'b0;
      ctr_ep_n = '0;
    end else if (ctr_set) begin
      ctr_n    = 1'b1;
      ctr_ep_n = upd_idx;
    end else if (ctr_clr) begin
      ctr_n    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      hs_q     <= HS_NONE;
      ctr_q    <= 1'b0;
      ctr_ep_q <= '0;
    end else begin
      hs_q <= hs_n;
      if (ctr_en) begin
        ctr_q    <= ctr_n;
        ctr_ep_q <= ctr_ep_n;
      end
    end
  end

  always_comb begin
    rd_data = 8'h00;
    if (int'(rd_idx) < NUM_EP) rd_data = regs[rd_idx];
  end

  assign hs_code  = hs_q;
  assign ctr_flag = ctr_q;
  assign ctr_ep   = ctr_ep_q;

  AST_CTR_HOLD: assert property (@(posedge clk) disable iff (!rst_ns)
    (ctr_q && !ctr_clr && !bus_rst) |=> ctr_q) else $error("ctr hold"); // R10

  AST_CTR_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_ns)
    (ctr_set && !bus_rst) |=> (hs_q == HS_ACK && ctr_q)) else $error("ctr ack"); // R5

  AST_BAD_CRC_SILENT: assert property (@(posedge clk) disable iff (!rst_ns)
    (tok_valid && !tok_crc_ok) |=> (hs_q == HS_NONE)) else $error("crc"); // R7

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_ns)
    !tok_valid |=> (hs_q == HS_NONE)) else $error("idle"); // R3

  AST_BUSRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_ns)
    bus_rst |=> (!ctr_q && regs[0] == EP0_RST)) else $error("busrst"); // R11

endmodule

// File: tb/usb_rx_hs_ctrl_test.sv
`timescale 1ns/100ps
module usb_rx_hs_ctrl_test;

  localparam int NEP = 3;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_rst, cfg_we, tok_valid, tok_setup, tok_pid1, tok_crc_ok, ctr_clr;
  logic [1:0] cfg_idx, rd_idx, ctr_ep, hs_code;
  logic [7:0] cfg_wdata, rd_data;
  logic [3:0] tok_ep;
  logic       ctr_flag;

  always #2 clk = ~clk;

  usb_rx_hs_ctrl #(.NUM_EP(NEP)) uut (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .rd_idx(rd_idx), .rd_data(rd_data),
    .tok_valid(tok_valid), .tok_setup(tok_setup), .tok_ep(tok_ep),
    .tok_pid1(tok_pid1), .tok_crc_ok(tok_crc_ok),
    .hs_code(hs_code), .ctr_clr(ctr_clr), .ctr_flag(ctr_flag), .ctr_ep(ctr_ep)
  );

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0] m_reg [NEP];
  logic       m_ctr;
  logic [1:0] m_ctr_ep;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_reg[0] = 8'h80;
    for (int i = 1; i < NEP; i++) m_reg[i] = 8'h00;
    m_ctr    = 1'b0;
    m_ctr_ep = 2'd0;
  endtask

  // compare all visible state; called in the low phase
  task automatic check_all(input string req, input logic [1:0] exp_hs);
    chk(req, "hs_code", int'(hs_code), int'(exp_hs));
    for (int i = 0; i < NEP; i++) begin
      rd_idx = 2'(i);
      #0.2;
      chk(req, $sformatf("reg%0d", i), int'(rd_data), int'(m_reg[i]));
    end
    chk(req, "ctr_flag", int'(ctr_flag), int'(m_ctr));
    if (m_ctr) chk(req, "ctr_ep", int'(ctr_ep), int'(m_ctr_ep));
  endtask

  task automatic do_write(input int idx, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    m_reg[idx] = (idx == 0) ? ((d & 8'h70) | 8'h80) : d;
    check_all("R2", 2'b00);
  endtask

  task automatic do_tok(input bit setup, input logic [3:0] ep, input bit pid1, input bit crc);
    logic [1:0] hs;
    string      tag;
    int         idx;
    logic [7:0] r;
    logic [3:0] a;
    hs = 2'b00; tag = "R3"; idx = -1;
    for (int i = NEP - 1; i >= 0; i--) begin
      a = (i == 0) ? 4'h0 : m_reg[i][3:0];
      if (a == ep) idx = i;
    end
    if (!crc) tag = "R7";
    else if (idx >= 0) begin
      r = m_reg[idx];
      if (setup) begin
        if (r[7] && r[5:4] != 2'b00) begin
          tag = "R8"; hs = 2'b01;
          if (!pid1) begin
            r[6] = 1'b1; r[5:4] = 2'b10; m_ctr = 1'b1; m_ctr_ep = 2'(idx);
          end else r[6] = 1'b0;
        end else tag = "R9";
      end else begin
        case (r[5:4])
          2'b00: begin tag = "R4"; hs = 2'b00; end
          2'b01: begin tag = "R4"; hs = 2'b11; end
          2'b10: begin tag = "R4"; hs = 2'b10; end
          default: begin
            hs = 2'b01;
            if (pid1 == r[6]) begin
              tag = "R5"; r[6] = ~r[6]; r[5:4] = 2'b10; m_ctr = 1'b1; m_ctr_ep = 2'(idx);
            end else tag = "R6";
          end
        endcase
      end
      m_reg[idx] = r;
    end
    @(negedge clk);
    tok_valid = 1'b1; tok_setup = setup; tok_ep = ep; tok_pid1 = pid1; tok_crc_ok = crc;
    @(negedge clk);
    tok_valid = 1'b0;
    check_all(tag, hs);
  endtask

  task automatic do_clr();
    @(negedge clk);
    ctr_clr = 1'b1;
    @(negedge clk);
    ctr_clr = 1'b0;
    m_ctr = 1'b0;
    check_all("R10", 2'b00);
  endtask

  task automatic do_busrst();
    @(negedge clk);
    bus_rst = 1'b1;
    @(negedge clk);
    bus_rst = 1'b0;
    model_reset();
    check_all("R11", 2'b00);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    int unused;
    unused = $urandom(32'h5EED_0042);
    rst_n = 1'b0; bus_rst = 0; cfg_we = 0; cfg_idx = 0; cfg_wdata = 0; rd_idx = 0;
    tok_valid = 0; tok_setup = 0; tok_ep = 0; tok_pid1 = 0; tok_crc_ok = 0; ctr_clr = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R1", 2'b00);

    // directed corner cases
    do_write(0, 8'h3F);               // R2: ep0 fixed bits
    do_write(1, 8'h31);               // ep1 valid, addr 1, DATA0 expected
    do_tok(1'b0, 4'h1, 1'b0, 1'b1);   // R5 accept
    do_tok(1'b0, 4'h1, 1'b1, 1'b1);   // R4 now NAK
    do_write(1, 8'h71);               // valid, expects DATA1
    do_tok(1'b0, 4'h1, 1'b0, 1'b1);   // R6 mismatch
    do_tok(1'b0, 4'h1, 1'b1, 1'b0);   // R7 bad crc
    do_write(2, 8'h92);               // control ep2 stalled, addr 2
    do_tok(1'b1, 4'h2, 1'b1, 1'b1);   // R8 SETUP DATA1
    do_tok(1'b1, 4'h2, 1'b0, 1'b1);   // R8 SETUP DATA0
    do_tok(1'b0, 4'h2, 1'b0, 1'b1);   // R4 NAK after setup
    do_tok(1'b1, 4'h1, 1'b0, 1'b1);   // R9 non-control
    do_tok(1'b0, 4'h7, 1'b0, 1'b1);   // R3 no match
    do_write(2, 8'h31);               // alias addr 1 behind ep1
    do_write(1, 8'h01);               // ep1 disabled at addr 1
    do_tok(1'b0, 4'h1, 1'b0, 1'b1);   // R3 lowest index wins (disabled)
    do_clr();                         // R10
    do_busrst();                      // R11

    for (int n = 0; n < 4000; n++) begin
      int op;
      op = $urandom_range(0, 19);
      if (op < 6) begin
        do_write($urandom_range(0, NEP - 1),
                 {$urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
                  2'($urandom_range(0, 3)), 4'($urandom_range(0, 3))});
      end else if (op < 18) begin
        do_tok($urandom_range(0, 3) == 0, ($urandom_range(0, 15) == 0) ? 4'h9 : 4'($urandom_range(0, 3)),
               $urandom_range(0, 1) == 1, $urandom_range(0, 7) != 0);
      end else if (op == 18) do_clr();
      else if ($urandom_range(0, 3) == 0) do_busrst();
    end

    finish_run();
  end

endmodule